// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Address Adapter

This block sits between the DMA request port of a 16-bit network controller and a 32-bit memory-master port. The controller issues a request with a device-relative address, a byte length, a direction and a pass-through flag. The adapter forms the memory address by OR-ing the request address with a base value held in a configuration register elsewhere. It then issues memory commands and streams 32-bit data beats between the two sides.

There are two modes. In swap mode (pass-through flag clear), the adapter forces even alignment of the address and the length. It exchanges the two bytes of every 16-bit unit in both directions. It also cuts writes into bursts of at most 64 bytes. In pass-through mode, the address, length and data go to memory unchanged as a single command.

The adapter handles one transfer at a time. It pulses a done strobe once the last command and the last data beat have both been handed over.

Top module: `hws_dma_adapter`

## Requirements
- R1: The memory address is the request address bitwise-ORed with `base_i`, sampled when the request is accepted. It is never the arithmetic sum of the two.
- R2: With `req_raw_i`=1, one command carries the ORed address and the request length unmodified. Data beats pass unmodified in both directions.
- R3: With `req_raw_i`=0, bit 0 of the command address and bit 0 of the length are forced to 0.
- R4: With `req_raw_i`=0, every data beat has the bytes of each halfword exchanged, on writes (`wdat_i`→`mw_data_o`) and on reads (`mr_data_i`→`rd_data_o`). Bits [15:8] trade places with [7:0], and bits [31:24] trade places with [23:16].
- R5: A swap-mode write is issued as consecutive commands of length min(remaining, 64). Each command's address is the previous one plus the previous length. Reads and pass-through writes use one command for the whole length.
- R6: A command offered on `mc_valid_o` keeps its address, length and direction until `mc_ready_i` accepts it.
- R7: `req_ready_o` is low from the cycle after an accepted non-empty request until the done pulse. Requests offered in that window produce no command and no data transfer.
- R8: A transfer moves exactly ceil(len/4) data beats, where len is the length after alignment. `done_o` is high for the cycle after the later of the last command handshake and the last beat handshake.
- R9: A request whose length after alignment is 0 issues no command and no data beat. `done_o` is high in the cycle after it is accepted.
- R10: During and after reset, `req_ready_o`=1 and `mc_valid_o`, `mw_valid_o`, `rd_valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | AW | Base value ORed into every address |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Adapter idle, request accepted |
| req_addr_i | input | AW | Device-relative byte address |
| req_len_i | input | LW | Byte length |
| req_write_i | input | 1 | 1 = write to memory, 0 = read |
| req_raw_i | input | 1 | 1 = pass-through, 0 = swap mode |
| mc_valid_o | output | 1 | Memory command valid |
| mc_ready_i | input | 1 | Memory command accepted |
| mc_addr_o | output | AW | Command byte address |
| mc_len_o | output | LW | Command byte length |
| mc_write_o | output | 1 | Command direction |
| wdat_valid_i | input | 1 | Device write data valid |
| wdat_ready_o | output | 1 | Device write data taken |
| wdat_i | input | DW | Device write data |
| mw_valid_o | output | 1 | Memory write data valid |
| mw_ready_i | input | 1 | Memory write data taken |
| mw_data_o | output | DW | Memory write data |
| mr_valid_i | input | 1 | Memory read data valid |
| mr_ready_o | output | 1 | Memory read data taken |
| mr_data_i | input | DW | Memory read data |
| rd_valid_o | output | 1 | Device read data valid |
| rd_ready_i | input | 1 | Device read data taken |
| rd_data_o | output | DW | Device read data |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The assertions assume that `mc_ready_i` is a plain acceptance signal and that the data handshakes only occur while the adapter opens the data window. They assume nothing about the stability of upstream data. The data paths are combinational, so a data value that changes while stalled is simply forwarded.

The bench drives every ready and valid input, and every data word, with fresh random values on each falling edge. This exercises stalls and back-to-back beats without ever relying on a hold rule. The `base_i` input changes only between transfers, never while one is in flight. A junk request is held on the request port for the whole time the adapter is busy and is withdrawn before the idle cycle that follows the done pulse.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int unsigned HWS_AW    = 32;
  localparam int unsigned HWS_LW    = 16;
  localparam int unsigned HWS_DW    = 32;
  localparam int unsigned HWS_BURST = 64;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } hws_state_e;
endpackage

// File: rtl/hws_lane_swap.sv
module hws_lane_swap #(
  parameter int unsigned DW = hws_pkg::HWS_DW
) (
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o
);
  localparam int unsigned NHALF = DW / 16;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign d_o[h*16 +: 16] = en_i ? {d_i[h*16 +: 8], d_i[h*16+8 +: 8]}
                                  : d_i[h*16 +: 16];
  end
endmodule

// File: rtl/hws_beat_cnt.sv
module hws_beat_cnt #(
  parameter int unsigned LW = hws_pkg::HWS_LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          fire_i,
  output logic          open_o,
  output logic          clear_o
);
  localparam int unsigned CW = LW - 1;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [LW:0]   len_up;

  // beats = ceil(len/4)
  assign len_up  = {1'b0, len_i} + (LW+1)'(3);
  assign cnt_nxt = cnt_q - CW'(fire_i);
  assign open_o  = cnt_q != '0;
  assign clear_o = cnt_nxt == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_up[LW:2];
    else             cnt_q <= cnt_nxt;
  end

  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> open_o);
endmodule

// File: rtl/hws_req_ctrl.sv
module hws_req_ctrl
  import hws_pkg::*;
#(
  parameter int unsigned AW    = HWS_AW,
  parameter int unsigned LW    = HWS_LW,
  parameter int unsigned BURST = HWS_BURST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          req_write_i,
  input  logic          req_raw_i,
  output logic          mc_valid_o,
  input  logic          mc_ready_i,
  output logic [AW-1:0] mc_addr_o,
  output logic [LW-1:0] mc_len_o,
  output logic          mc_write_o,
  input  logic          beats_clear_i,
  output logic          accept_o,
  output logic [LW-1:0] eff_len_o,
  output logic          busy_o,
  output logic          write_o,
  output logic          raw_o,
  output logic          done_o
);
  localparam logic [LW-1:0] BURST_L = LW'(BURST);

  hws_state_e    state_q;
  logic          write_q, raw_q, done_q;
  logic [AW-1:0] addr_q, eff_addr;
  logic [LW-1:0] rem_q, rem_nxt, blen;
  logic          split, cmd_fire, finish;

  always_comb begin
    eff_addr = req_addr_i | base_i;
    if (!req_raw_i) eff_addr[0] = 1'b0;
    eff_len_o = req_raw_i ? req_len_i : {req_len_i[LW-1:1], 1'b0};
  end

  assign busy_o      = state_q == ST_BUSY;
  assign req_ready_o = !busy_o;
  assign accept_o    = req_valid_i && req_ready_o;
  assign split       = write_q && !raw_q;
  assign blen        = (split && rem_q > BURST_L) ? BURST_L : rem_q;
  assign mc_valid_o  = busy_o && rem_q != '0;
  assign mc_addr_o   = addr_q;
  assign mc_len_o    = blen;
  assign mc_write_o  = write_q;
  assign cmd_fire    = mc_valid_o && mc_ready_i;
  assign rem_nxt     = cmd_fire ? rem_q - blen : rem_q;
  assign finish      = busy_o && rem_nxt == '0 && beats_clear_i;
  assign write_o     = write_q;
  assign raw_o       = raw_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      raw_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (accept_o) begin
      state_q <= (eff_len_o != '0) ? ST_BUSY : ST_IDLE;
      done_q  <= eff_len_o == '0;
      write_q <= req_write_i;
      raw_q   <= req_raw_i;
      addr_q  <= eff_addr;
      rem_q   <= eff_len_o;
    end else begin
      done_q <= finish;
      rem_q  <= rem_nxt;
      if (cmd_fire) addr_q <= addr_q + AW'(blen);
      if (finish)   state_q <= ST_IDLE;
    end
  end

  a_r3_even_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o && !raw_q |-> !mc_addr_o[0] && !mc_len_o[0]);
  a_r5_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o && mc_write_o && !raw_q |-> mc_len_o <= BURST_L);
  a_r6_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o && !mc_ready_i |=> mc_valid_o && $stable(mc_addr_o)
                                   && $stable(mc_len_o) && $stable(mc_write_o));
  a_r7_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o |-> !req_ready_o);
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mc_valid_o);
  a_r9_empty_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && eff_len_o == '0 |=> done_o && !mc_valid_o);
endmodule

// File: rtl/hws_dma_adapter.sv
module hws_dma_adapter
  import hws_pkg::*;
#(
  parameter int unsigned AW    = HWS_AW,
  parameter int unsigned LW    = HWS_LW,
  parameter int unsigned DW    = HWS_DW,
  parameter int unsigned BURST = HWS_BURST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          req_write_i,
  input  logic          req_raw_i,
  output logic          mc_valid_o,
  input  logic          mc_ready_i,
  output logic [AW-1:0] mc_addr_o,
  output logic [LW-1:0] mc_len_o,
  output logic          mc_write_o,
  input  logic          wdat_valid_i,
  output logic          wdat_ready_o,
  input  logic [DW-1:0] wdat_i,
  output logic          mw_valid_o,
  input  logic          mw_ready_i,
  output logic [DW-1:0] mw_data_o,
  input  logic          mr_valid_i,
  output logic          mr_ready_o,
  input  logic [DW-1:0] mr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);
  logic          accept, busy, write_q, raw_q, beats_clear, beat_open;
  logic          wopen, ropen, wfire, rfire;
  logic [LW-1:0] eff_len;

  hws_req_ctrl #(.AW(AW), .LW(LW), .BURST(BURST)) u_ctrl (
    .clk_i, .rst_ni, .base_i,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i, .req_write_i, .req_raw_i,
    .mc_valid_o, .mc_ready_i, .mc_addr_o, .mc_len_o, .mc_write_o,
    .beats_clear_i(beats_clear),
    .accept_o     (accept),
    .eff_len_o    (eff_len),
    .busy_o       (busy),
    .write_o      (write_q),
    .raw_o        (raw_q),
    .done_o
  );

  hws_beat_cnt #(.LW(LW)) u_beats (
    .clk_i, .rst_ni,
    .load_i (accept),
    .len_i  (eff_len),
    .fire_i (wfire || rfire),
    .open_o (beat_open),
    .clear_o(beats_clear)
  );

  assign wopen        = busy && write_q && beat_open;
  assign ropen        = busy && !write_q && beat_open;
  assign mw_valid_o   = wopen && wdat_valid_i;
  assign wdat_ready_o = wopen && mw_ready_i;
  assign wfire        = mw_valid_o && mw_ready_i;
  assign rd_valid_o   = ropen && mr_valid_i;
  assign mr_ready_o   = ropen && rd_ready_i;
  assign rfire        = rd_valid_o && rd_ready_i;

  hws_lane_swap #(.DW(DW)) u_wswap (.en_i(!raw_q), .d_i(wdat_i),    .d_o(mw_data_o));
  hws_lane_swap #(.DW(DW)) u_rswap (.en_i(!raw_q), .d_i(mr_data_i), .d_o(rd_data_o));

  a_r4_wr_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_valid_o && !raw_q |-> mw_data_o[15:8] == wdat_i[7:0]
                           && mw_data_o[7:0] == wdat_i[15:8]);
  a_r2_rd_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && raw_q |-> rd_data_o == mr_data_i);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mw_valid_o && !rd_valid_o);
endmodule

// File: tb/tb_hws_dma_adapter.sv
module tb_hws_dma_adapter;
  localparam int AW = 32, LW = 16, DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0, req_raw_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic          req_ready_o, mc_valid_o, mc_write_o, wdat_ready_o, mw_valid_o;
  logic          mr_ready_o, rd_valid_o, done_o;
  logic [AW-1:0] mc_addr_o;
  logic [LW-1:0] mc_len_o;
  logic [DW-1:0] mw_data_o, rd_data_o;
  logic          mc_ready_i = 0, wdat_valid_i = 0, mw_ready_i = 0, mr_valid_i = 0, rd_ready_i = 0;
  logic [DW-1:0] wdat_i = '0, mr_data_i = '0;

  always #10 clk = ~clk;

  hws_dma_adapter dut (
    .clk_i(clk), .rst_ni(rst_n), .base_i,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i, .req_write_i, .req_raw_i,
    .mc_valid_o, .mc_ready_i, .mc_addr_o, .mc_len_o, .mc_write_o,
    .wdat_valid_i, .wdat_ready_o, .wdat_i, .mw_valid_o, .mw_ready_i, .mw_data_o,
    .mr_valid_i, .mr_ready_o, .mr_data_i, .rd_valid_o, .rd_ready_i, .rd_data_o,
    .done_o
  );

  typedef struct { logic [AW-1:0] a; logic [LW-1:0] l; logic w; } cmd_t;
  cmd_t exp_q[$];
  int   vecs = 0, errs = 0;
  int   beats_seen = 0, beats_exp = 0, done_cnt = 0;
  logic cur_raw = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_data(input logic [DW-1:0] d, input logic raw);
    logic [DW-1:0] r;
    for (int b = 0; b < DW/8; b++)
      r[b*8 +: 8] = raw ? d[b*8 +: 8] : d[(b ^ 1)*8 +: 8];
    return r;
  endfunction

  // random handshakes and data on every falling edge
  always @(negedge clk) begin
    mc_ready_i   <= 1'($urandom_range(0, 1));
    wdat_valid_i <= 1'($urandom_range(0, 1));
    mw_ready_i   <= 1'($urandom_range(0, 1));
    mr_valid_i   <= 1'($urandom_range(0, 1));
    rd_ready_i   <= 1'($urandom_range(0, 1));
    wdat_i       <= $urandom;
    mr_data_i    <= $urandom;
  end

  // reference comparison, sampled mid low phase
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (mc_valid_o && mc_ready_i) begin
        if (exp_q.size() == 0)
          check(1'b0, "R7", "unexpected command addr", 64'(mc_addr_o), 64'(0));
        else begin
          cmd_t e;
          e = exp_q.pop_front();
          check(mc_addr_o == e.a, "R5", "command addr", 64'(mc_addr_o), 64'(e.a));
          check(mc_len_o == e.l, "R5", "command len", 64'(mc_len_o), 64'(e.l));
          check(mc_write_o == e.w, "R5", "command dir", 64'(mc_write_o), 64'(e.w));
        end
      end
      if (mw_valid_o && mw_ready_i) begin
        beats_seen++;
        check(mw_data_o == ref_data(wdat_i, cur_raw), cur_raw ? "R2" : "R4",
              "write beat", 64'(mw_data_o), 64'(ref_data(wdat_i, cur_raw)));
      end
      if (rd_valid_o && rd_ready_i) begin
        beats_seen++;
        check(rd_data_o == ref_data(mr_data_i, cur_raw), cur_raw ? "R2" : "R4",
              "read beat", 64'(rd_data_o), 64'(ref_data(mr_data_i, cur_raw)));
      end
      if (done_o) begin
        done_cnt++;
        check(exp_q.size() == 0, "R8", "commands left at done", 64'(exp_q.size()), 64'(0));
        check(beats_seen == beats_exp, "R8", "beats at done", 64'(beats_seen), 64'(beats_exp));
      end
    end
  end

  task automatic run_txn(input logic [AW-1:0] base, input logic [AW-1:0] addr,
                         input logic [LW-1:0] len, input logic wr, input logic raw);
    logic [AW-1:0] ea;
    int            el, rem, b, waited;
    @(negedge clk);
    base_i = base;
    ea = addr | base;
    if (!raw) ea[0] = 1'b0;
    el = raw ? int'(len) : int'(len) & ~1;
    if (el != 0) begin
      if (wr && !raw) begin
        rem = el;
        while (rem > 0) begin
          b = (rem > 64) ? 64 : rem;
          exp_q.push_back('{ea, LW'(b), wr});
          ea = ea + AW'(b);
          rem -= b;
        end
      end else exp_q.push_back('{ea, LW'(el), wr});
    end
    beats_exp = (el + 3) / 4;
    beats_seen = 0;
    done_cnt = 0;
    cur_raw = raw;
    req_addr_i = addr; req_len_i = len; req_write_i = wr; req_raw_i = raw;
    req_valid_i = 1'b1;
    @(negedge clk);
    if (el == 0) begin
      req_valid_i = 1'b0;
      #5;
      check(done_o == 1'b1, "R9", "done after empty request", 64'(done_o), 64'(1));
      check(mc_valid_o == 1'b0, "R9", "no command for empty request", 64'(mc_valid_o), 64'(0));
    end else begin
      // junk request held while busy must be ignored
      req_addr_i = 32'hDEAD_BEE0; req_len_i = 16'd40; req_write_i = !wr; req_raw_i = 1'b1;
      #5;
      check(req_ready_o == 1'b0, "R7", "ready while busy", 64'(req_ready_o), 64'(0));
      waited = 0;
      while (!done_o && waited < 5000) begin
        @(negedge clk);
        waited++;
      end
      req_valid_i = 1'b0;
      if (waited >= 5000)
        check(1'b0, "R8", "transfer timed out", 64'(waited), 64'(0));
    end
    repeat (3) @(negedge clk);
    #6;
    check(done_cnt == 1, "R8", "done pulse count", 64'(done_cnt), 64'(1));
    check(mc_valid_o == 1'b0 && req_ready_o == 1'b1, "R7", "idle after done",
          64'({mc_valid_o, req_ready_o}), 64'(1));
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "R8", "watchdog expired", 64'(0), 64'(1));
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(req_ready_o == 1'b1, "R10", "ready in reset", 64'(req_ready_o), 64'(1));
    check(!mc_valid_o && !mw_valid_o && !rd_valid_o && !done_o, "R10", "valids in reset",
          64'({mc_valid_o, mw_valid_o, rd_valid_o, done_o}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    check(req_ready_o == 1'b1 && !mc_valid_o && !done_o, "R10", "idle after reset",
          64'({req_ready_o, mc_valid_o, done_o}), 64'(4));

    run_txn(32'h1000_0000, 32'h0000_0013, 16'd7,   1'b0, 1'b1); // R1 R2 raw read, odd kept
    run_txn(32'h2000_0000, 32'h0000_0105, 16'd9,   1'b0, 1'b0); // R3 R4 swap read
    run_txn(32'h0000_00F0, 32'h0000_003C, 16'd12,  1'b0, 1'b0); // R1 OR not add -> 0xFC
    run_txn(32'h4000_0000, 32'h0000_0201, 16'd201, 1'b1, 1'b0); // R5 64,64,64,8
    run_txn(32'h4000_0000, 32'h0000_0400, 16'd64,  1'b1, 1'b0); // R5 exact single burst
    run_txn(32'h4000_0000, 32'h0000_0400, 16'd65,  1'b1, 1'b0); // R3 R5 65 -> 64
    run_txn(32'h4000_0000, 32'h0000_0800, 16'd129, 1'b1, 1'b0); // R5 64,64
    run_txn(32'h0800_0000, 32'h0000_0031, 16'd201, 1'b1, 1'b1); // R2 raw write, one command
    run_txn(32'h0000_0000, 32'h0000_0040, 16'd1,   1'b1, 1'b0); // R9 1 -> 0
    run_txn(32'h0000_0000, 32'h0000_0041, 16'd0,   1'b0, 1'b1); // R9 raw zero
    run_txn(32'h0000_0F00, 32'h0000_00FE, 16'd130, 1'b0, 1'b0); // R4 long swap read
    run_txn(32'h0000_0003, 32'h0000_0010, 16'd6,   1'b1, 1'b0); // R1 R3 base bit0 dropped

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule